// File: doc/BRIEF.md
# Codeword Output Assembler

This block sits at the back of a serial block encoder. It joins two bit streams that arrive at different times into one contiguous codeword. The first stream is the stored message, replayed one bit at a time. The second is the serial parity that the encoder produces once the message has been consumed. Each source has its own valid strobe. The assembler takes exactly the message length in bits from the message source and then exactly the parity length in bits from the parity source. It puts them out on a single bit lane with start, end and valid strobes. An output counter that runs to the codeword length (message plus parity) drives those strobes.

The block also paces the input side. A ready flag tells the upstream frame writer when a new frame may begin. The start of a frame captures the two lengths and a frame-valid flag. Ready then stays low until the whole codeword has left the block. A frame whose parameters are unusable produces no output at all, and ready returns as soon as its input end has been seen. Computing the parity is not part of this block.

Top module: `cwa_assembler`

## Requirements
- R1: During and directly after reset, `ready` is 1 and `out_vld`, `out_start` and `out_end` are 0.
- R2: An `in_start` pulse while `ready` is 1 captures `msg_len`, `par_len` and `cfg_ok`, and `ready` is 0 on the following cycle. An `in_start` pulse while `ready` is 0 changes nothing: neither the lengths in use nor `ready`.
- R3: An accepted frame emits the `msg_len` message bits in arrival order, then the `par_len` parity bits in arrival order. Each bit is emitted one cycle after the cycle in which its source valid was accepted. Idle cycles on a source give idle cycles at the output.
- R4: `out_vld` is 1 for exactly `msg_len + par_len` cycles per accepted frame, and is 0 on every other cycle.
- R5: `out_start` is 1 only together with the first message bit of a frame. `out_end` is 1 only together with the last parity bit. Both occur once per frame, and never outside a cycle with `out_vld`.
- R6: When the last message beat and the first parity beat are presented on adjacent cycles, the two output bits appear on adjacent cycles with no gap between them.
- R7: While message bits are still owed, `par_vld` and `par_bit` are ignored. Once all message bits have been taken, `msg_vld` and `msg_bit` are ignored.
- R8: After an accepted frame, `ready` stays 0 through the cycle of `out_end` and is 1 on the cycle after it.
- R9: A frame captured with `cfg_ok` = 0, or with a zero `msg_len` or `par_len`, produces no `out_vld`, `out_start` or `out_end`. `ready` returns to 1 on the cycle after that frame's `in_end`.
- R10: While `ready` is 1, source valids produce no output strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_start | input | 1 | First-bit strobe of an incoming frame on the input side |
| in_end | input | 1 | Last-bit strobe of an incoming frame on the input side |
| cfg_ok | input | 1 | Frame parameters valid, captured with `in_start` |
| msg_len | input | LEN_W | Message length in bits, captured with `in_start` |
| par_len | input | LEN_W | Parity length in bits, captured with `in_start` |
| msg_bit | input | 1 | Replayed message bit |
| msg_vld | input | 1 | Message bit valid |
| par_bit | input | 1 | Serial parity bit |
| par_vld | input | 1 | Parity bit valid |
| out_bit | output | 1 | Codeword bit |
| out_vld | output | 1 | Codeword bit valid |
| out_start | output | 1 | First codeword bit of a frame |
| out_end | output | 1 | Last codeword bit of a frame |
| ready | output | 1 | Input side may start a new frame |

## Verification
The checker relies on three things about the inputs. `in_start` is the only way a frame begins. The lengths and `cfg_ok` are meaningful in the cycle of an accepted `in_start`. A frame is judged unusable on those same captured values. The bench keeps within this by presenting each frame's parameters only with its accepted start pulse. It also raises `in_end` exactly once per frame, and drives source beats only while a frame is open, except in the deliberate cases that probe R7, R9 and R10. The sweep covers every message length from 1 to 5 and every parity length from 1 to 4, each under gapped or gapless delivery, with or without stray opposite-source valids and with or without a stray restart.

// File: rtl/cwa_pkg.sv
// Package: shared types for the codeword output assembler.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package cwa_pkg;

    // Frame pacing states.
    //   FS_READY : no frame open, input side may start one
    //   FS_RUN   : accepted frame with usable parameters, bits flowing
    //   FS_DROP  : frame with unusable parameters, waiting for its input end
    //   FS_FLUSH : last codeword bit just issued, ready held low one cycle
    typedef enum logic [1:0] {
        FS_READY = 2'd0,
        FS_RUN   = 2'd1,
        FS_DROP  = 2'd2,
        FS_FLUSH = 2'd3
    } frame_state_t;

    // Width of a count that must hold the sum of two LEN_W-bit lengths.
    function automatic int sum_width(input int len_w);
        return len_w + 1;
    endfunction

endpackage

// File: rtl/cwa_frame_ctrl.sv
// Module: cwa_frame_ctrl
// Paces frames. Captures the lengths and the validity flag on an accepted
// start, decides whether the frame will produce output, and drives ready.
// Assumes: done pulses once, on the cycle the last codeword beat is taken.
module cwa_frame_ctrl
    import cwa_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_start,
    input  logic             in_end,
    input  logic             cfg_ok,
    input  logic [LEN_W-1:0] msg_len,
    input  logic [LEN_W-1:0] par_len,
    input  logic             done,
    output logic             ready,
    output logic             run,
    output logic [CNT_W-1:0] msg_len_q,
    output logic [CNT_W-1:0] tot_len_q
);

    frame_state_t state_q;
    frame_state_t state_d;
    logic         accept;
    logic         usable;
    logic [CNT_W-1:0] msg_ext;
    logic [CNT_W-1:0] par_ext;

    // Widen the lengths so that their sum cannot overflow.
    always_comb begin
        msg_ext = {{(CNT_W-LEN_W){1'b0}}, msg_len};
        par_ext = {{(CNT_W-LEN_W){1'b0}}, par_len};
    end

    // A start counts only while the block is idle. Zero lengths make a frame unusable.
    always_comb begin
        accept = in_start && (state_q == FS_READY);
        usable = cfg_ok && (msg_len != '0) && (par_len != '0);
    end

    // Next-state logic of the pacing machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_READY: begin
                if (accept) begin
                    if (usable)
                        state_d = FS_RUN;
                    else if (!in_end)
                        state_d = FS_DROP;
                end
            end
            FS_RUN:   if (done)   state_d = FS_FLUSH;
            FS_DROP:  if (in_end) state_d = FS_READY;
            FS_FLUSH: state_d = FS_READY;
            default:  state_d = FS_READY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FS_READY;
        else
            state_q <= state_d;
    end

    // Capture the frame lengths on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_len_q <= '0;
            tot_len_q <= '0;
        end else if (accept) begin
            msg_len_q <= msg_ext;
            tot_len_q <= msg_ext + par_ext;
        end
    end

    // Decoded state flags.
    always_comb begin
        ready = (state_q == FS_READY);
        run   = (state_q == FS_RUN);
    end

endmodule

// File: rtl/cwa_beat_counter.sv
// Module: cwa_beat_counter
// Output counter. Tracks the beat position within the codeword, chooses the
// source for that position, and flags the first and the last beat.
// Assumes: while run is high, tot_len_q >= 2 and 1 <= msg_len_q < tot_len_q.
module cwa_beat_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             msg_vld,
    input  logic             par_vld,
    input  logic [CNT_W-1:0] msg_len_q,
    input  logic [CNT_W-1:0] tot_len_q,
    output logic             take,
    output logic             sel_par,
    output logic             first,
    output logic             last
);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] last_pos;

    // Choose the source that owns the current position. Only its valid counts.
    always_comb begin
        last_pos = tot_len_q - {{(CNT_W-1){1'b0}}, 1'b1};
        sel_par  = (pos_q >= msg_len_q);
        take     = run && (sel_par ? par_vld : msg_vld);
        first    = (pos_q == '0);
        last     = (pos_q == last_pos);
    end

    // Advance on each taken beat, and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (!run)
            pos_q <= '0;
        else if (take)
            pos_q <= last ? '0 : pos_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/cwa_out_stage.sv
// Module: cwa_out_stage
// Two-way source multiplexer and output register. Issues the selected bit and
// the frame strobes one cycle after a beat is taken.
// Assumes: take, first and last come from the same cycle's counter state.
module cwa_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic sel_par,
    input  logic first,
    input  logic last,
    input  logic msg_bit,
    input  logic par_bit,
    output logic out_bit,
    output logic out_vld,
    output logic out_start,
    output logic out_end
);

    logic mux_bit;

    // Pick the parity bit once all message bits have been taken.
    always_comb begin
        mux_bit = sel_par ? par_bit : msg_bit;
    end

    // Register the bit and its strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit   <= 1'b0;
            out_vld   <= 1'b0;
            out_start <= 1'b0;
            out_end   <= 1'b0;
        end else begin
            out_vld   <= take;
            out_start <= take && first;
            out_end   <= take && last;
            if (take)
                out_bit <= mux_bit;
        end
    end

endmodule

// File: rtl/cwa_assembler.sv
// Module: cwa_assembler (top)
// Joins a replayed message stream and a later serial parity stream into one
// codeword with start, end and valid strobes. Paces the input side with ready.
// Assumes: the sources present beats only for the frame that is open.
module cwa_assembler
    import cwa_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_start,
    input  logic             in_end,
    input  logic             cfg_ok,
    input  logic [LEN_W-1:0] msg_len,
    input  logic [LEN_W-1:0] par_len,
    input  logic             msg_bit,
    input  logic             msg_vld,
    input  logic             par_bit,
    input  logic             par_vld,
    output logic             out_bit,
    output logic             out_vld,
    output logic             out_start,
    output logic             out_end,
    output logic             ready
);

    localparam int CNT_W = sum_width(LEN_W);

    logic             run;
    logic             take;
    logic             sel_par;
    logic             first;
    logic             last;
    logic             done;
    logic [CNT_W-1:0] msg_len_q;
    logic [CNT_W-1:0] tot_len_q;

    // The frame is complete when its last beat is taken.
    always_comb begin
        done = take && last;
    end

    cwa_frame_ctrl #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_start  (in_start),
        .in_end    (in_end),
        .cfg_ok    (cfg_ok),
        .msg_len   (msg_len),
        .par_len   (par_len),
        .done      (done),
        .ready     (ready),
        .run       (run),
        .msg_len_q (msg_len_q),
        .tot_len_q (tot_len_q)
    );

    cwa_beat_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .msg_vld   (msg_vld),
        .par_vld   (par_vld),
        .msg_len_q (msg_len_q),
        .tot_len_q (tot_len_q),
        .take      (take),
        .sel_par   (sel_par),
        .first     (first),
        .last      (last)
    );

    cwa_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .sel_par   (sel_par),
        .first     (first),
        .last      (last),
        .msg_bit   (msg_bit),
        .par_bit   (par_bit),
        .out_bit   (out_bit),
        .out_vld   (out_vld),
        .out_start (out_start),
        .out_end   (out_end)
    );

endmodule

// File: rtl/cwa_assembler_chk.sv
// Module: cwa_assembler_chk
// Port-level checker for cwa_assembler, attached by bind.
// Assumes: frame parameters are meaningful in the cycle of an accepted start.
module cwa_assembler_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_start,
    input logic             cfg_ok,
    input logic [LEN_W-1:0] msg_len,
    input logic [LEN_W-1:0] par_len,
    input logic             out_vld,
    input logic             out_start,
    input logic             out_end,
    input logic             ready
);

    logic [LEN_W:0] exp_tot;
    logic [LEN_W:0] seen;
    logic           bad_q;

    // Record the expected codeword length and usability of each accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_tot <= '0;
            bad_q   <= 1'b0;
        end else if (in_start && ready) begin
            exp_tot <= {1'b0, msg_len} + {1'b0, par_len};
            bad_q   <= !cfg_ok || (msg_len == '0) || (par_len == '0);
        end
    end

    // Count the valid beats issued so far in the current codeword.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= '0;
        else if (out_end)
            seen <= '0;
        else if (out_vld)
            seen <= seen + 1'b1;
    end

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_start && ready) |=> !ready);

    // R4
    beat_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> (seen + 1'b1 == exp_tot));

    // R5
    start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> (out_vld && !out_end));

    // R5
    end_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> out_vld);

    // R5
    first_is_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && seen == '0) |-> out_start);

    // R8
    ready_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> (!ready ##1 ready));

    // R9
    bad_frame_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_q && !ready) |-> !(out_vld || out_start || out_end));

    // R10
    quiet_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !out_vld);

endmodule

bind cwa_assembler cwa_assembler_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_start  (in_start),
    .cfg_ok    (cfg_ok),
    .msg_len   (msg_len),
    .par_len   (par_len),
    .out_vld   (out_vld),
    .out_start (out_start),
    .out_end   (out_end),
    .ready     (ready)
);

// File: tb/cwa_assembler_test.sv
module cwa_assembler_test;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             in_start = 1'b0, in_end = 1'b0, cfg_ok = 1'b0;
    logic [LEN_W-1:0] msg_len = '0, par_len = '0;
    logic             msg_bit = 1'b0, msg_vld = 1'b0, par_bit = 1'b0, par_vld = 1'b0;
    logic             out_bit, out_vld, out_start, out_end, ready;

    cwa_assembler #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_end(in_end),
        .cfg_ok(cfg_ok), .msg_len(msg_len), .par_len(par_len),
        .msg_bit(msg_bit), .msg_vld(msg_vld), .par_bit(par_bit), .par_vld(par_vld),
        .out_bit(out_bit), .out_vld(out_vld), .out_start(out_start),
        .out_end(out_end), .ready(ready)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic exp_bit [64];

    // Monitor state, sampled on the falling edge.
    logic mon_bit [64];
    int   mon_cyc [64];
    int   mon_n, n_start, n_end, start_idx, end_idx, end_cyc, rise_cyc, stray_strobe;
    logic prev_ready;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (out_vld) begin
            if (mon_n < 64) begin
                mon_bit[mon_n] = out_bit;
                mon_cyc[mon_n] = cyc;
            end
            if (out_start) begin n_start++; start_idx = mon_n; end
            if (out_end) begin n_end++; end_idx = mon_n; end_cyc = cyc; end
            mon_n++;
        end else if (out_start || out_end) begin
            stray_strobe++;
        end
        if (ready && !prev_ready && rise_cyc < 0) rise_cyc = cyc;
        prev_ready = ready;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        mon_n = 0; n_start = 0; n_end = 0; start_idx = -1; end_idx = -1;
        end_cyc = -1; rise_cyc = -1; stray_strobe = 0; prev_ready = ready;
    endtask

    function automatic logic rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // mode[0]: idle gaps, mode[1]: stray opposite-source valids, mode[2]: restart while busy
    task automatic run_frame(input int m, input int p, input bit ok, input int mode);
        bit usable = ok && m != 0 && p != 0;
        int bad_bits = 0;
        @(negedge clk);
        chk(ready == 1'b1, "R2 ready before start", ready, 1);
        clr_mon();
        for (int i = 0; i < m + p; i++) exp_bit[i] = rnd();
        in_start = 1'b1; msg_len = LEN_W'(m); par_len = LEN_W'(p); cfg_ok = ok;
        @(negedge clk);
        in_start = 1'b0; msg_len = LEN_W'(9); par_len = LEN_W'(9); cfg_ok = 1'b1;
        chk(ready == 1'b0, "R2 ready low after start", ready, 0);
        if (!usable) begin
            for (int i = 0; i < m + p; i++) begin
                msg_vld = 1'b1; par_vld = 1'b1; msg_bit = exp_bit[i]; par_bit = exp_bit[i];
                @(negedge clk);
            end
            msg_vld = 1'b0; par_vld = 1'b0;
            in_end = 1'b1;
            @(negedge clk);
            in_end = 1'b0;
            chk(ready == 1'b1, "R9 ready after in_end", ready, 1);
            repeat (2) @(negedge clk);
            chk(mon_n == 0 && n_start == 0 && n_end == 0 && stray_strobe == 0,
                "R9 no output for unusable frame", mon_n + n_start + n_end + stray_strobe, 0);
            return;
        end
        in_end = 1'b1;
        @(negedge clk);
        in_end = 1'b0;
        if (mode[2]) in_start = 1'b1;
        for (int i = 0; i < m; i++) begin
            if (mode[0] && i % 2 == 1) begin
                msg_vld = 1'b0; par_vld = mode[1]; par_bit = rnd();
                @(negedge clk);
                in_start = 1'b0;
            end
            msg_vld = 1'b1; msg_bit = exp_bit[i];
            par_vld = mode[1]; par_bit = ~exp_bit[m];
            @(negedge clk);
            if (in_start) chk(ready == 1'b0, "R2 restart ignored", ready, 0);
            in_start = 1'b0;
        end
        for (int j = 0; j < p; j++) begin
            if (mode[0] && j % 2 == 1) begin
                par_vld = 1'b0; msg_vld = mode[1]; msg_bit = rnd();
                @(negedge clk);
            end
            par_vld = 1'b1; par_bit = exp_bit[m + j];
            msg_vld = mode[1]; msg_bit = ~exp_bit[m + j];
            @(negedge clk);
        end
        msg_vld = 1'b0; par_vld = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < m + p; i++) if (mon_bit[i] !== exp_bit[i]) bad_bits++;
        chk(mon_n == m + p, "R4 valid beat count", mon_n, m + p);
        chk(bad_bits == 0, mode[1] ? "R7 bits with stray valids" : "R3 bit order",
            bad_bits, 0);
        chk(n_start == 1 && start_idx == 0 && stray_strobe == 0, "R5 start position",
            start_idx, 0);
        chk(n_end == 1 && end_idx == m + p - 1, "R5 end position", end_idx, m + p - 1);
        chk(rise_cyc == end_cyc + 1, "R8 ready rise after end", rise_cyc, end_cyc + 1);
        if (!mode[0])
            chk(mon_cyc[m] == mon_cyc[m - 1] + 1, "R6 no gap message to parity",
                mon_cyc[m] - mon_cyc[m - 1], 1);
        else if (m >= 2)
            chk(mon_cyc[1] == mon_cyc[0] + 2, "R3 source gap reproduced",
                mon_cyc[1] - mon_cyc[0], 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ready == 1'b1 && out_vld == 1'b0 && out_start == 1'b0 && out_end == 1'b0,
            "R1 reset state", {ready, out_vld, out_start, out_end}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1 && out_vld == 1'b0, "R1 state after reset", {ready, out_vld}, 2'b10);

        // R10: source beats while idle
        clr_mon();
        for (int i = 0; i < 6; i++) begin
            msg_vld = 1'b1; par_vld = i[0]; msg_bit = rnd(); par_bit = rnd();
            @(negedge clk);
        end
        msg_vld = 1'b0; par_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk(mon_n == 0 && stray_strobe == 0, "R10 idle sources silent", mon_n, 0);

        for (int m = 1; m <= 5; m++)
            for (int p = 1; p <= 4; p++)
                for (int mode = 0; mode < 8; mode++)
                    run_frame(m, p, 1'b1, mode);

        run_frame(3, 2, 1'b0, 0);   // R9 flag low
        run_frame(0, 3, 1'b1, 0);   // R9 zero message length
        run_frame(4, 0, 1'b1, 0);   // R9 zero parity length
        run_frame(2, 2, 1'b1, 0);   // recovery after unusable frames

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R4: actual %0d expected %0d", cyc, 200000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule